// File: doc/BRIEF.md
# USB Root Port Status and Control Register Bank

This block holds the per-port status and control words of a full-speed/low-speed USB root hub. Each port has one 16-bit word. The word records whether a device is connected and whether the port is enabled. It keeps sticky flags that note changes to either of those, a low-speed indication and a port reset control. A port model signals device arrival and removal with single-cycle event inputs. The host reaches every port through one write channel and one combinational read channel, both selected by a port index.

The block returns two results to the rest of the controller. The first is a one-cycle bus-reset request, raised when software starts a port reset while a device is present. The second is a per-port enabled flag that tells the packet router which ports may receive traffic. A controller-wide reset input returns every word to its idle value and then rebuilds the connect state of any device that is still plugged in. A read of an index beyond the implemented ports returns a fixed "no port" pattern.

Top module: `usbp_root_ports`

## Requirements
- R1: After `rst_n` is released, every implemented port word reads 0x0080 and both `bus_reset` and `port_enabled` are all low.
- R2: Word fields: bit 0 connected, bit 1 connect changed, bit 2 enabled, bit 3 enable changed, bit 8 low-speed device, bit 9 port reset. Bits 10 to 15 are host scratch. Bit 7 always reads 1 and bits 4 to 6 always read 0.
- R3: A write to port `wr_idx` loads bits 2 and 9 to 15 from `wr_data`. Bits 0, 1, 3 and 4 to 8 keep their old values, except as R4 allows.
- R4: A 1 written to bit 1 or bit 3 clears that bit. A 0 leaves it unchanged.
- R5: When a write moves bit 9 from 0 to 1 on a port with a device present, `bus_reset` for that port is high for exactly the one cycle after the write edge. No pulse is raised when bit 9 is already 1 or when no device is present.
- R6: An attach event sets bits 0 and 1, copies `dev_low_speed` into bit 8, and marks the device present.
- R7: A detach event marks the device absent. If bit 0 is set, it clears bit 0 and sets bit 1. If bit 2 is set, it clears bit 2 and sets bit 3.
- R8: A read with `rd_idx` at or beyond `N_PORTS` returns 0xFF7F. A write to such an index changes no port.
- R9: `port_enabled` for a port is high exactly when a device is present and bit 2 of its word is set.
- R10: `hc_reset` sets every word to 0x0080, cancels any write in the same cycle (and its reset pulse), and then sets bits 0 and 1, with bit 8 from `dev_low_speed`, on each port whose device is present.
- R11: In one cycle the write is applied first and events after it. When attach and detach arrive together, detach takes effect and attach is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hc_reset | input | 1 | Controller-wide reset of all port words, one cycle |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDX_W | Port index of the read |
| rd_data | output | 16 | Selected port word, or 0xFF7F when out of range |
| dev_attach | input | N_PORTS | Per-port device arrival event |
| dev_detach | input | N_PORTS | Per-port device removal event |
| dev_low_speed | input | N_PORTS | Per-port speed of the attached device, 1 for low speed |
| bus_reset | output | N_PORTS | Per-port one-cycle bus-reset request |
| port_enabled | output | N_PORTS | Per-port packet-routing enable |

## Verification
The hardest situations to reach are those where several sources of change hit the same port in one cycle. Examples are a write that sets the enable bit while a detach arrives, a simultaneous attach and detach, and a controller reset that coincides with a reset-starting write. Each of these depends on the order R11 and R10 define.

The bench forces each such collision once as a directed case. It then runs a long seeded random phase. In that phase writes are frequent, events are rare and overlapping, and the controller reset appears occasionally, so the collisions recur with varied prior state. Every cycle is checked against a bench-side model of the word rules.

// File: rtl/usbp_pkg.sv
package usbp_pkg;
  localparam int unsigned WORD_W = 16;

  localparam int unsigned B_CONN     = 0;
  localparam int unsigned B_CONN_CHG = 1;
  localparam int unsigned B_ENA      = 2;
  localparam int unsigned B_ENA_CHG  = 3;
  localparam int unsigned B_LOWSPD   = 8;
  localparam int unsigned B_PRST     = 9;

  localparam logic [WORD_W-1:0] KEEP_MASK   = 16'h01FB;
  localparam logic [WORD_W-1:0] CLR1_MASK   = 16'h000A;
  localparam logic [WORD_W-1:0] IDLE_WORD   = 16'h0080;
  localparam logic [WORD_W-1:0] ABSENT_WORD = 16'hFF7F;
endpackage

// File: rtl/usbp_rst_sync.sv
module usbp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/usbp_port_cell.sv
module usbp_port_cell
  import usbp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hc_reset,
  input  logic              wr_hit,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              attach,
  input  logic              detach,
  input  logic              low_speed,
  output logic [WORD_W-1:0] word_q,
  output logic              present_q,
  output logic              bus_reset_q
);
  logic [WORD_W-1:0] word_d;
  logic              present_d;
  logic              pulse_d;
  logic              upd_en;

  // next-state: write merge, then events, then controller reset
  always_comb begin
    word_d = word_q;
    if (wr_hit) begin
      word_d = (word_q & KEEP_MASK) | (wr_data & ~KEEP_MASK);
      word_d = word_d & ~(wr_data & CLR1_MASK);
    end

    if (detach) begin
      if (word_d[B_CONN]) begin
        word_d[B_CONN]     = 1'b0;
        word_d[B_CONN_CHG] = 1'b1;
      end
      if (word_d[B_ENA]) begin
        word_d[B_ENA]     = 1'b0;
        word_d[B_ENA_CHG] = 1'b1;
      end
    end else if (attach) begin
      word_d[B_CONN]     = 1'b1;
      word_d[B_CONN_CHG] = 1'b1;
      word_d[B_LOWSPD]   = low_speed;
    end

    present_d = detach ? 1'b0 : (attach ? 1'b1 : present_q);

    if (hc_reset) begin
      word_d = IDLE_WORD;
      if (present_d) begin
        word_d[B_CONN]     = 1'b1;
        word_d[B_CONN_CHG] = 1'b1;
        word_d[B_LOWSPD]   = low_speed;
      end
    end

    pulse_d = wr_hit && !hc_reset && wr_data[B_PRST] && !word_q[B_PRST] && present_q;
    upd_en  = wr_hit || attach || detach || hc_reset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q      <= IDLE_WORD;
      present_q   <= 1'b0;
      bus_reset_q <= 1'b0;
    end else begin
      if (upd_en) begin
        word_q    <= word_d;
        present_q <= present_d;
      end
      bus_reset_q <= pulse_d;
    end
  end
endmodule

// File: rtl/usbp_read_mux.sv
module usbp_read_mux
  import usbp_pkg::*;
#(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [N_PORTS-1:0][WORD_W-1:0] port_word,
  input  logic [IDX_W-1:0]               rd_idx,
  output logic [WORD_W-1:0]              rd_data
);
  always_comb begin
    rd_data = ABSENT_WORD;
    for (int k = 0; k < N_PORTS; k++) begin
      if (rd_idx == IDX_W'(k)) rd_data = port_word[k];
    end
  end
endmodule

// File: rtl/usbp_root_ports.sv
module usbp_root_ports
  import usbp_pkg::*;
#(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hc_reset,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [15:0]          wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [15:0]          rd_data,
  input  logic [N_PORTS-1:0]   dev_attach,
  input  logic [N_PORTS-1:0]   dev_detach,
  input  logic [N_PORTS-1:0]   dev_low_speed,
  output logic [N_PORTS-1:0]   bus_reset,
  output logic [N_PORTS-1:0]   port_enabled
);
  logic                          rst_sync_n;
  logic [N_PORTS-1:0][WORD_W-1:0] port_word;
  logic [N_PORTS-1:0]            present_v;

  usbp_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar i = 0; i < N_PORTS; i++) begin : g_port
    logic wr_hit;
    assign wr_hit = wr_en && (wr_idx == IDX_W'(i));

    usbp_port_cell i_cell (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .hc_reset    (hc_reset),
      .wr_hit      (wr_hit),
      .wr_data     (wr_data),
      .attach      (dev_attach[i]),
      .detach      (dev_detach[i]),
      .low_speed   (dev_low_speed[i]),
      .word_q      (port_word[i]),
      .present_q   (present_v[i]),
      .bus_reset_q (bus_reset[i])
    );

    assign port_enabled[i] = present_v[i] && port_word[i][B_ENA];
  end

  usbp_read_mux #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) i_rd_mux (
    .port_word (port_word),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/usbp_root_ports_chk.sv
module usbp_root_ports_chk #(
  parameter int unsigned N_PORTS = 2,
  parameter int unsigned IDX_W   = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hc_reset,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [15:0]                wr_data,
  input logic [IDX_W-1:0]           rd_idx,
  input logic [15:0]                rd_data,
  input logic [N_PORTS-1:0]         dev_attach,
  input logic [N_PORTS-1:0]         dev_detach,
  input logic [N_PORTS-1:0]         bus_reset,
  input logic [N_PORTS-1:0][15:0]   port_word,
  input logic [N_PORTS-1:0]         present_v
);
  logic idx_out;
  assign idx_out = ({1'b0, rd_idx} >= (IDX_W+1)'(N_PORTS));

  assert_absent_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_out |-> rd_data == 16'hFF7F);

  assert_fixed_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_out |-> (rd_data[7] && rd_data[6:4] == 3'b000));

  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset[i] |=> !bus_reset[i]);

    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_reset[i] |-> $past(wr_en && wr_idx == IDX_W'(i) && wr_data[9] && !hc_reset
                             && present_v[i] && !port_word[i][9]));

    assert_attach_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && dev_attach[i] && !dev_detach[i]) |->
        (port_word[i][0] && port_word[i][1] && present_v[i]));

    assert_detach_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && dev_detach[i]) |->
        (!port_word[i][0] && !port_word[i][2] && !present_v[i]));

    assert_w1c_conn_chg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && wr_en && wr_idx == IDX_W'(i) && wr_data[1] && !dev_attach[i]
            && !dev_detach[i] && !hc_reset) |-> !port_word[i][1]);

    assert_hc_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && hc_reset) |->
        (!port_word[i][2] && !port_word[i][3] && !port_word[i][9] && !bus_reset[i]));
  end
endmodule

bind usbp_root_ports usbp_root_ports_chk #(.N_PORTS(N_PORTS), .IDX_W(IDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .hc_reset   (hc_reset),
  .wr_en      (wr_en),
  .wr_idx     (wr_idx),
  .wr_data    (wr_data),
  .rd_idx     (rd_idx),
  .rd_data    (rd_data),
  .dev_attach (dev_attach),
  .dev_detach (dev_detach),
  .bus_reset  (bus_reset),
  .port_word  (port_word),
  .present_v  (present_v)
);

// File: tb/test_usbp_root_ports.sv
`timescale 1ns/100ps
module test_usbp_root_ports;
  localparam int NP = 2;
  localparam int IW = 2;

  logic          clk;
  logic          rst_n;
  logic          hc_reset;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [15:0]   wr_data;
  logic [IW-1:0] rd_idx;
  logic [15:0]   rd_data;
  logic [NP-1:0] dev_attach, dev_detach, dev_low_speed;
  logic [NP-1:0] bus_reset, port_enabled;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_word [NP];
  logic        m_pres [NP];
  logic        m_pulse[NP];

  usbp_root_ports #(.N_PORTS(NP), .IDX_W(IW)) i_usbp_root_ports (
    .clk(clk), .rst_n(rst_n), .hc_reset(hc_reset), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .dev_attach(dev_attach),
    .dev_detach(dev_detach), .dev_low_speed(dev_low_speed), .bus_reset(bus_reset),
    .port_enabled(port_enabled)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input int idx);
    if (idx >= NP) return 16'hFF7F;   // R8
    return m_word[idx];
  endfunction

  // expected word after one cycle, following R3, R4, R6, R7, R10, R11
  task automatic model(input logic hc, input logic we, input int widx, input logic [15:0] wd,
                       input logic [NP-1:0] att, input logic [NP-1:0] det,
                       input logic [NP-1:0] ls);
    for (int p = 0; p < NP; p++) begin
      logic [15:0] w;
      logic        pr;
      w = m_word[p];
      m_pulse[p] = we && (widx == p) && !hc && wd[9] && !w[9] && m_pres[p];
      if (we && widx == p) begin
        w[2] = wd[2];
        w[15:9] = wd[15:9];
        if (wd[1]) w[1] = 1'b0;
        if (wd[3]) w[3] = 1'b0;
      end
      pr = m_pres[p];
      if (det[p]) begin
        if (w[0]) begin w[0] = 1'b0; w[1] = 1'b1; end
        if (w[2]) begin w[2] = 1'b0; w[3] = 1'b1; end
        pr = 1'b0;
      end else if (att[p]) begin
        w[0] = 1'b1; w[1] = 1'b1; w[8] = ls[p]; pr = 1'b1;
      end
      if (hc) begin
        w = 16'h0080;
        if (pr) begin w[0] = 1'b1; w[1] = 1'b1; w[8] = ls[p]; end
      end
      m_word[p] = w;
      m_pres[p] = pr;
    end
  endtask

  task automatic check_all(input string tag);
    for (int p = 0; p < NP; p++) begin
      check({15'd0, bus_reset[p]}, {15'd0, m_pulse[p]}, {tag, " R5 pulse"});
      check({15'd0, port_enabled[p]}, {15'd0, m_pres[p] & m_word[p][2]}, {tag, " R9 enable"});
    end
    for (int k = 0; k < 4; k++) begin
      rd_idx = IW'(k);
      #0.5;
      check(rd_data, exp_read(k), {tag, " read"});
    end
  endtask

  task automatic step(input logic hc, input logic we, input int widx, input logic [15:0] wd,
                      input logic [NP-1:0] att, input logic [NP-1:0] det,
                      input logic [NP-1:0] ls, input string tag);
    @(negedge clk);
    hc_reset = hc; wr_en = we; wr_idx = IW'(widx); wr_data = wd;
    dev_attach = att; dev_detach = det; dev_low_speed = ls;
    model(hc, we, widx, wd, att, det, ls);
    @(posedge clk);
    #0.5;
    check_all(tag);
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 0, 16'h0, '0, '0, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd20250917;
    void'($urandom(seed));
    rst_n = 1'b0; hc_reset = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    rd_idx = '0; dev_attach = '0; dev_detach = '0; dev_low_speed = '0;
    for (int p = 0; p < NP; p++) begin
      m_word[p] = 16'h0080; m_pres[p] = 1'b0; m_pulse[p] = 1'b0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #0.5;
    check_all("R1 reset");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'h0080, "R1 idle word");
    check({8'd0, rd_data[7:0]} & 16'h00F0, 16'h0080, "R2 fixed bits");
    rd_idx = 2'd2; #0.5; check(rd_data, 16'hFF7F, "R8 absent port");

    // R5: reset bit set with no device -> no pulse; R9 no device -> not enabled
    step(0, 1, 0, 16'h0204, 2'b00, 2'b00, 2'b00, "R5 no device");
    check({15'd0, bus_reset[0]}, 16'd0, "R5 no pulse without device");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'h0284, "R3 write");
    // R6: low-speed attach
    step(0, 0, 0, 16'h0, 2'b01, 2'b00, 2'b01, "R6 attach");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'h0387, "R6 attach low speed");
    check({15'd0, port_enabled[0]}, 16'd1, "R9 enabled with device");
    step(0, 1, 0, 16'h0000, 2'b00, 2'b00, 2'b00, "R3 clear en");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'h0183, "R3 preserved bits");
    // R5: 0->1 with device
    step(0, 1, 0, 16'h0204, 2'b00, 2'b00, 2'b00, "R5 edge");
    check({15'd0, bus_reset[0]}, 16'd1, "R5 pulse raised");
    idle("R5 after");
    check({15'd0, bus_reset[0]}, 16'd0, "R5 pulse one cycle");
    // R4 + R5 no pulse when already set
    step(0, 1, 0, 16'h0206, 2'b00, 2'b00, 2'b00, "R4 w1c");
    check({15'd0, bus_reset[0]}, 16'd0, "R5 no pulse when set");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'h0385, "R4 conn chg cleared");
    step(0, 1, 0, 16'hFC0C, 2'b00, 2'b00, 2'b00, "R3 scratch");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'hFD85, "R3 scratch bits");
    // R7 detach
    step(0, 0, 0, 16'h0, 2'b00, 2'b01, 2'b00, "R7 detach");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'hFD8A, "R7 detach flags");
    // R11 ordering
    step(0, 1, 1, 16'h0004, 2'b11, 2'b01, 2'b00, "R11 collide");
    rd_idx = 2'd1; #0.5; check(rd_data, 16'h0087, "R11 write then attach");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'hFD8A, "R11 detach wins");
    // R10 controller reset cancels write
    step(1, 1, 1, 16'h0200, 2'b00, 2'b00, 2'b00, "R10 hc reset");
    check({15'd0, bus_reset[1]}, 16'd0, "R10 no pulse");
    rd_idx = 2'd1; #0.5; check(rd_data, 16'h0083, "R10 reattach");
    rd_idx = 2'd0; #0.5; check(rd_data, 16'h0080, "R10 cleared");
    // R8 write to absent index
    step(0, 1, 3, 16'hFFFF, 2'b00, 2'b00, 2'b00, "R8 absent write");

    for (int n = 0; n < 800; n++) begin
      logic          hc, we;
      int            wi;
      logic [15:0]   wd;
      logic [NP-1:0] att, det, ls;
      hc = ($urandom % 32) == 0;
      we = ($urandom % 2) == 0;
      wi = int'($urandom % 4);
      wd = 16'($urandom);
      if (($urandom % 4) == 0) wd[9] = 1'b0;
      for (int p = 0; p < NP; p++) begin
        att[p] = ($urandom % 8) == 0;
        det[p] = ($urandom % 8) == 0;
        ls[p]  = 1'($urandom);
      end
      step(hc, we, wi, wd, att, det, ls, "R3 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule